// File: doc/BRIEF.md
# Power-Off Acknowledge Aggregation Controller

This controller runs the power-off handshake of a switch that has one upstream port and several downstream ports. A turn-off request on the upstream side is copied to every downstream port that is active at that moment. The controller then waits until each of those ports has answered, either with an acknowledge or by running out its timer. After that it issues a single acknowledge upstream and reports the upstream link as ready for power removal. Message encoding and link training are outside the block. Each one is reduced to a pulse or a request/done pair at the ports.

A packet can arrive upstream while answers are still outstanding. In that case the controller abandons the aggregation and returns to idle without acknowledging. The downstream handshakes are left running. A packet that arrives after the upstream acknowledge has been issued is dropped. Any other packet addressed to a downstream port is forwarded at once if that port's link is active. If the link is not active, the controller first requests a retrain, and it forwards the packet only after the retrain-done pulse. Packets that arrive for a port while its link is retraining are counted and are all forwarded after the retrain completes.

States of the aggregation machine: IDLE, COLLECT, DONE. Transitions: any state to COLLECT on a turn-off request, COLLECT to IDLE on an upstream packet (abandon), COLLECT to DONE when every port has answered. States of each port's forwarding machine: FW_IDLE, FW_WAKE, FW_SEND. Transitions: FW_IDLE to FW_WAKE on a packet for a link that is not active, FW_WAKE to FW_SEND on retrain done, FW_SEND to FW_IDLE when no packets remain.

Top module: `pwroff_ack_agg`

## Requirements
- R1: One cycle after `turnoff_i` is sampled high, `dn_turnoff_o` pulses for one cycle on exactly the ports whose `dn_active_i` bit was high in that cycle.
- R2: `up_ack_o` pulses once, in the cycle after COLLECT sees every port answered, and only then. From that cycle on, `up_link_o` reads 1 (ready for power removal) until the next turn-off request. Otherwise it reads 0 (active).
- R3: An upstream packet (`up_pkt_i`) sampled in COLLECT without a turn-off request abandons aggregation. The state returns to IDLE and no `up_ack_o` follows.
- R4: A packet sampled in DONE is dropped. It causes no `dn_fwd_o` and no `dn_retrain_o`.
- R5: Abandonment does not stop the downstream ports. Their acknowledges are still recorded and their timers still expire, and each expiry still pulses `dn_force_rdy_o`.
- R6: At broadcast, each port's timer loads `tmo_val_i`. A port still unanswered `tmo_val_i` cycles after broadcast pulses `dn_force_rdy_o` and counts as answered. A value of 0 counts as answered at once, with no force pulse. A port inactive at broadcast counts as answered.
- R7: A non-local packet addressed by `up_pkt_dst_i` to a port whose `dn_link_i` code is 0 (active) gives a one-cycle `dn_fwd_o` pulse on that port in the next cycle.
- R8: A packet for a port whose link code is not 0 raises `dn_retrain_o` for that port, which holds until `dn_retrain_done_i`. Then one `dn_fwd_o` pulse per cycle is issued for that packet and for every packet that arrived during the retrain.
- R9: A turn-off request is accepted in every state and restarts the sequence. `up_link_o` returns to 0 and new capture and broadcast take place.
- R10: A packet with `up_pkt_local_i` high targets the controller itself and is never forwarded.
- R11: After reset no output pulses, `up_link_o` is 0, and every port counts as answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| turnoff_i | input | 1 | Upstream turn-off request pulse |
| up_pkt_i | input | 1 | Upstream packet arrival pulse |
| up_pkt_local_i | input | 1 | Packet targets the controller itself |
| up_pkt_dst_i | input | IDX_W | Downstream port index of the packet |
| tmo_val_i | input | TMR_W | Timeout in clock cycles |
| dn_active_i | input | NUM_DN | Per-port link active flag |
| dn_ack_i | input | NUM_DN | Per-port acknowledge pulse |
| dn_link_i | input | 2*NUM_DN | Per-port link code: 0 active, 1 ready for removal, 2 detect, 3 other |
| dn_retrain_done_i | input | NUM_DN | Per-port retrain complete pulse |
| dn_turnoff_o | output | NUM_DN | Per-port turn-off pulse |
| dn_force_rdy_o | output | NUM_DN | Per-port timeout pulse: move link to ready |
| dn_retrain_o | output | NUM_DN | Per-port retrain request (level) |
| dn_fwd_o | output | NUM_DN | Per-port forward-packet pulse |
| up_ack_o | output | 1 | Upstream acknowledge pulse |
| up_link_o | output | 2 | Upstream link code: 0 active, 1 ready for removal |

## Verification
The assertions check on every cycle the rules that hold locally:
- an upstream acknowledge only ever follows a fully answered vector and comes with the ready link code;
- an abandoning packet is never followed by an acknowledge;
- a timeout always marks its port answered;
- a retrain request holds, with no forward issued, until its done pulse;
- the pending packet count cannot overflow.

Only the bench's scenarios can show the rest: the timeout latency against the programmed value, downstream timers that keep running after an abandonment, that every queued packet is forwarded after a wake, and that a turn-off request in DONE or mid-collection restarts cleanly.

// File: rtl/pwroff_agg_pkg.sv
package pwroff_agg_pkg;

    typedef enum logic [1:0] {
        LNK_ACTIVE = 2'd0,
        LNK_RDY    = 2'd1,
        LNK_DETECT = 2'd2,
        LNK_OTHER  = 2'd3
    } link_e;

    typedef enum logic [1:0] {
        AG_IDLE    = 2'd0,
        AG_COLLECT = 2'd1,
        AG_DONE    = 2'd2
    } agg_st_e;

    typedef enum logic [1:0] {
        FW_IDLE = 2'd0,
        FW_WAKE = 2'd1,
        FW_SEND = 2'd2
    } fw_st_e;

endpackage

// File: rtl/agg_ctl_fsm.sv
module agg_ctl_fsm
    import pwroff_agg_pkg::*;
#(
    parameter int NUM_DN = 4,
    localparam int IDX_W = (NUM_DN > 1) ? $clog2(NUM_DN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              turnoff_i,
    input  logic              pkt_i,
    input  logic              pkt_local_i,
    input  logic [IDX_W-1:0]  pkt_dst_i,
    input  logic [NUM_DN-1:0] ackd_i,
    output logic              start_o,
    output logic [NUM_DN-1:0] fwd_req_o,
    output logic              up_ack_o,
    output logic [1:0]        up_link_o
);

    agg_st_e st_q, st_d;
    logic    ack_d;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        ack_d = 1'b0;
        if (turnoff_i) begin
            st_d = AG_COLLECT;
        end else begin
            unique case (st_q)
                AG_IDLE: st_d = AG_IDLE;
                AG_COLLECT: begin
                    if (pkt_i) begin
                        st_d = AG_IDLE;
                    end else if (&ackd_i) begin
                        st_d  = AG_DONE;
                        ack_d = 1'b1;
                    end
                end
                AG_DONE: st_d = AG_DONE;
                default: st_d = AG_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AG_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_ack_o <= 1'b0;
        else        up_ack_o <= ack_d;
    end

    assign start_o   = turnoff_i;
    assign up_link_o = (st_q == AG_DONE) ? LNK_RDY : LNK_ACTIVE;

    for (genvar p = 0; p < NUM_DN; p++) begin : g_req
        assign fwd_req_o[p] = pkt_i && !pkt_local_i && (st_q != AG_DONE)
                              && (pkt_dst_i == IDX_W'(p));
    end

    assert_ack_needs_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack_o |-> $past(&ackd_i));
    assert_ack_link_rdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack_o |-> (up_link_o == LNK_RDY));
    assert_abandon_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AG_COLLECT && pkt_i && !turnoff_i) |=> (!up_ack_o && up_link_o == LNK_ACTIVE));
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        turnoff_i |=> (up_link_o == LNK_ACTIVE && !up_ack_o));

endmodule

// File: rtl/agg_port_collect.sv
module agg_port_collect #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             active_i,
    input  logic             ack_i,
    input  logic [TMR_W-1:0] tmo_val_i,
    output logic             ackd_o,
    output logic             turnoff_o,
    output logic             force_rdy_o
);

    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ackd_o      <= 1'b1;
            tmr_q       <= '0;
            turnoff_o   <= 1'b0;
            force_rdy_o <= 1'b0;
        end else begin
            turnoff_o   <= 1'b0;
            force_rdy_o <= 1'b0;
            if (start_i) begin
                ackd_o    <= !active_i || (tmo_val_i == '0);
                tmr_q     <= tmo_val_i;
                turnoff_o <= active_i;
            end else if (!ackd_o) begin
                if (ack_i) begin
                    ackd_o <= 1'b1;
                end else if (tmr_q == TMR_W'(1)) begin
                    ackd_o      <= 1'b1;
                    force_rdy_o <= 1'b1;
                end else begin
                    tmr_q <= tmr_q - TMR_W'(1);
                end
            end
        end
    end

    assert_inactive_answered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !active_i) |=> (ackd_o && !turnoff_o));
    assert_timeout_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        force_rdy_o |-> ackd_o);
    assert_ack_recorded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ackd_o && ack_i && !start_i) |=> ackd_o);

endmodule

// File: rtl/agg_port_fwd.sv
module agg_port_fwd
    import pwroff_agg_pkg::*;
#(
    parameter int PEND_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [1:0] link_i,
    input  logic       retrain_done_i,
    output logic       fwd_o,
    output logic       retrain_o
);

    fw_st_e            st_q, st_d;
    logic [PEND_W-1:0] pend_q, pend_d;
    logic              fwd_d, emit;

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        fwd_d  = 1'b0;
        emit   = 1'b0;
        unique case (st_q)
            FW_IDLE: begin
                if (req_i) begin
                    if (link_i == LNK_ACTIVE) begin
                        fwd_d = 1'b1;
                    end else begin
                        st_d   = FW_WAKE;
                        pend_d = PEND_W'(1);
                    end
                end
            end
            FW_WAKE: begin
                pend_d = pend_q + PEND_W'(req_i);
                if (retrain_done_i) st_d = FW_SEND;
            end
            FW_SEND: begin
                emit   = (pend_q != '0);
                fwd_d  = emit;
                pend_d = pend_q + PEND_W'(req_i) - PEND_W'(emit);
                if (pend_d == '0) st_d = FW_IDLE;
            end
            default: st_d = FW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FW_IDLE;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fwd_o <= 1'b0;
        else        fwd_o <= fwd_d;
    end

    assign retrain_o = (st_q == FW_WAKE);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != FW_IDLE && pend_q == {PEND_W{1'b1}}) |-> !req_i);
    assert_retrain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retrain_o && !retrain_done_i) |=> retrain_o);
    assert_no_fwd_waking_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retrain_o && !retrain_done_i) |=> !fwd_o);

endmodule

// File: rtl/pwroff_ack_agg.sv
module pwroff_ack_agg
    import pwroff_agg_pkg::*;
#(
    parameter int NUM_DN = 4,
    parameter int TMR_W  = 16,
    parameter int PEND_W = 3,
    localparam int IDX_W = (NUM_DN > 1) ? $clog2(NUM_DN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                turnoff_i,
    input  logic                up_pkt_i,
    input  logic                up_pkt_local_i,
    input  logic [IDX_W-1:0]    up_pkt_dst_i,
    input  logic [TMR_W-1:0]    tmo_val_i,
    input  logic [NUM_DN-1:0]   dn_active_i,
    input  logic [NUM_DN-1:0]   dn_ack_i,
    input  logic [2*NUM_DN-1:0] dn_link_i,
    input  logic [NUM_DN-1:0]   dn_retrain_done_i,
    output logic [NUM_DN-1:0]   dn_turnoff_o,
    output logic [NUM_DN-1:0]   dn_force_rdy_o,
    output logic [NUM_DN-1:0]   dn_retrain_o,
    output logic [NUM_DN-1:0]   dn_fwd_o,
    output logic                up_ack_o,
    output logic [1:0]          up_link_o
);

    logic              start;
    logic [NUM_DN-1:0] ackd;
    logic [NUM_DN-1:0] fwd_req;

    agg_ctl_fsm #(.NUM_DN(NUM_DN)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .turnoff_i  (turnoff_i),
        .pkt_i      (up_pkt_i),
        .pkt_local_i(up_pkt_local_i),
        .pkt_dst_i  (up_pkt_dst_i),
        .ackd_i     (ackd),
        .start_o    (start),
        .fwd_req_o  (fwd_req),
        .up_ack_o   (up_ack_o),
        .up_link_o  (up_link_o)
    );

    for (genvar p = 0; p < NUM_DN; p++) begin : g_port
        agg_port_collect #(.TMR_W(TMR_W)) u_col (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (start),
            .active_i   (dn_active_i[p]),
            .ack_i      (dn_ack_i[p]),
            .tmo_val_i  (tmo_val_i),
            .ackd_o     (ackd[p]),
            .turnoff_o  (dn_turnoff_o[p]),
            .force_rdy_o(dn_force_rdy_o[p])
        );

        agg_port_fwd #(.PEND_W(PEND_W)) u_fwd (
            .clk           (clk),
            .rst_n         (rst_n),
            .req_i         (fwd_req[p]),
            .link_i        (dn_link_i[2*p +: 2]),
            .retrain_done_i(dn_retrain_done_i[p]),
            .fwd_o         (dn_fwd_o[p]),
            .retrain_o     (dn_retrain_o[p])
        );
    end

endmodule

// File: tb/pwroff_ack_agg_tb.sv
`timescale 1ns/1ps
module pwroff_ack_agg_tb;
    localparam int N  = 4;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic toff = 1'b0, pkt = 1'b0, loc = 1'b0;
    logic [1:0] dst = '0;
    logic [TW-1:0] tmo = '0;
    logic [N-1:0] act = '0, ack = '0, rdone = '0;
    logic [2*N-1:0] link = '0;
    logic [N-1:0] o_toff, o_frc, o_rt, o_fwd;
    logic o_ack;
    logic [1:0] o_link;

    always #2 clk = ~clk;

    pwroff_ack_agg #(.NUM_DN(N), .TMR_W(TW), .PEND_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .turnoff_i(toff), .up_pkt_i(pkt),
        .up_pkt_local_i(loc), .up_pkt_dst_i(dst), .tmo_val_i(tmo),
        .dn_active_i(act), .dn_ack_i(ack), .dn_link_i(link),
        .dn_retrain_done_i(rdone), .dn_turnoff_o(o_toff),
        .dn_force_rdy_o(o_frc), .dn_retrain_o(o_rt), .dn_fwd_o(o_fwd),
        .up_ack_o(o_ack), .up_link_o(o_link)
    );

    int vecs = 0, errs = 0;
    bit fin = 0;

    // behavioural reference model
    int m_st;
    bit m_ackd[N];
    int m_tmr[N];
    int m_wst[N];
    int m_pend[N];
    bit [N-1:0] m_toff, m_frc, m_fwd;
    bit m_ack, allk, fok, em;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ack = 0; m_toff = '0; m_frc = '0; m_fwd = '0;
            for (int p = 0; p < N; p++) begin
                m_ackd[p] = 1; m_tmr[p] = 0; m_wst[p] = 0; m_pend[p] = 0;
            end
        end else begin
            allk = 1;
            for (int p = 0; p < N; p++) if (!m_ackd[p]) allk = 0;
            fok = pkt && !loc && (m_st != 2);
            m_ack = 0; m_toff = '0; m_frc = '0; m_fwd = '0;
            if (toff) m_st = 1;
            else if (m_st == 1) begin
                if (pkt) m_st = 0;
                else if (allk) begin m_st = 2; m_ack = 1; end
            end
            for (int p = 0; p < N; p++) begin
                if (toff) begin
                    m_ackd[p] = !act[p] || (tmo == 0);
                    m_tmr[p] = tmo;
                    m_toff[p] = act[p];
                end else if (!m_ackd[p]) begin
                    if (ack[p]) m_ackd[p] = 1;
                    else if (m_tmr[p] == 1) begin m_ackd[p] = 1; m_frc[p] = 1; end
                    else m_tmr[p] = m_tmr[p] - 1;
                end
                em = 0;
                if (m_wst[p] == 0) begin
                    if (fok && dst == p) begin
                        if (link[2*p +: 2] == 2'd0) m_fwd[p] = 1;
                        else begin m_wst[p] = 1; m_pend[p] = 1; end
                    end
                end else if (m_wst[p] == 1) begin
                    if (fok && dst == p) m_pend[p]++;
                    if (rdone[p]) m_wst[p] = 2;
                end else begin
                    em = (m_pend[p] > 0);
                    m_fwd[p] = em;
                    m_pend[p] = m_pend[p] + ((fok && dst == p) ? 1 : 0) - (em ? 1 : 0);
                    if (m_pend[p] == 0) m_wst[p] = 0;
                end
            end
        end
    end

    task automatic cmp(input string req, input logic [31:0] a, input logic [31:0] e);
        vecs++;
        if (a !== e) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, a, e, $time);
        end
    endtask

    logic [N-1:0] m_rt;
    always @(negedge clk) if (rst_n && !fin) begin
        for (int p = 0; p < N; p++) m_rt[p] = (m_wst[p] == 1);
        cmp("R1 dn_turnoff", 32'(o_toff), 32'(m_toff));
        cmp("R2 up_ack", 32'(o_ack), 32'(m_ack));
        cmp("R2 up_link", 32'(o_link), (m_st == 2) ? 32'd1 : 32'd0);
        cmp("R6 force_rdy", 32'(o_frc), 32'(m_frc));
        cmp("R7 fwd", 32'(o_fwd), 32'(m_fwd));
        cmp("R8 retrain", 32'(o_rt), 32'(m_rt));
    end

    // pulse counters seen at the ports
    int c_ack = 0, c_frc = 0, c_toff = 0;
    int c_fwd[N];
    initial for (int p = 0; p < N; p++) c_fwd[p] = 0;
    always @(negedge clk) if (rst_n) begin
        c_ack += int'(o_ack);
        c_frc += $countones(o_frc);
        c_toff += $countones(o_toff);
        for (int p = 0; p < N; p++) c_fwd[p] += int'(o_fwd[p]);
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask
    task automatic clr;
        toff = 0; pkt = 0; loc = 0; ack = '0; rdone = '0;
    endtask
    task automatic do_toff;
        toff = 1; tick(1); clr();
    endtask
    task automatic send(input logic l, input int d);
        pkt = 1; loc = l; dst = 2'(d); tick(1); clr();
    endtask
    task automatic acks(input logic [N-1:0] m);
        ack = m; tick(1); clr();
    endtask

    int b_ack, b_frc, b_toff, b_fwd;

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R11 reset state
        cmp("R11 reset outputs", 32'({o_toff, o_frc, o_rt, o_fwd, o_ack}), 32'd0);
        cmp("R11 reset link", 32'(o_link), 32'd0);

        // R1/R2: all active, staggered acks
        act = 4'b1111; tmo = 40; b_ack = c_ack; b_toff = c_toff;
        do_toff();
        acks(4'b0001); tick(2); acks(4'b0110); tick(2);
        cmp("R2 no ack while one port open", 32'(c_ack - b_ack), 32'd0);
        acks(4'b1000); tick(3);
        cmp("R1 turnoff count", 32'(c_toff - b_toff), 32'd4);
        cmp("R2 one ack", 32'(c_ack - b_ack), 32'd1);
        cmp("R2 link ready", 32'(o_link), 32'd1);

        // R6: inactive ports count as answered
        act = 4'b0101; b_ack = c_ack; b_toff = c_toff;
        do_toff(); acks(4'b0101); tick(3);
        cmp("R6 inactive turnoffs", 32'(c_toff - b_toff), 32'd2);
        cmp("R6 inactive ack", 32'(c_ack - b_ack), 32'd1);

        // R6: timeouts
        act = 4'b1111; tmo = 6; b_ack = c_ack; b_frc = c_frc;
        do_toff(); tick(12);
        cmp("R6 timeout pulses", 32'(c_frc - b_frc), 32'd4);
        cmp("R6 timeout ack", 32'(c_ack - b_ack), 32'd1);
        tmo = 0; b_ack = c_ack; b_frc = c_frc;
        do_toff(); tick(4);
        cmp("R6 zero timeout ack", 32'(c_ack - b_ack), 32'd1);
        cmp("R6 zero timeout no force", 32'(c_frc - b_frc), 32'd0);

        // R3/R5: abandonment by local packet
        tmo = 8; b_ack = c_ack; b_frc = c_frc; b_fwd = c_fwd[0];
        do_toff(); tick(2); send(1'b1, 0);
        acks(4'b1100); tick(15);
        cmp("R3 no ack after abandon", 32'(c_ack - b_ack), 32'd0);
        cmp("R3 link active", 32'(o_link), 32'd0);
        cmp("R5 downstream timers run", 32'(c_frc - b_frc), 32'd2);
        cmp("R10 local not forwarded", 32'(c_fwd[0] - b_fwd), 32'd0);

        // R4: packet in DONE dropped
        tmo = 3; do_toff(); tick(6);
        cmp("R4 in done", 32'(o_link), 32'd1);
        b_fwd = c_fwd[1];
        send(1'b0, 1); tick(4);
        cmp("R4 dropped", 32'(c_fwd[1] - b_fwd), 32'd0);
        cmp("R4 no retrain", 32'(o_rt), 32'd0);

        // R9: turnoff in DONE and mid-collection
        toff = 1; tick(1); clr();
        cmp("R9 link active again", 32'(o_link), 32'd0);
        tick(6);
        tmo = 10; b_ack = c_ack; b_toff = c_toff;
        do_toff(); tick(3); do_toff(); tick(15);
        cmp("R9 two broadcasts", 32'(c_toff - b_toff), 32'd8);
        cmp("R9 single ack", 32'(c_ack - b_ack), 32'd1);

        // R7: forward on active link, abandoning the collection
        tmo = 20; do_toff(); tick(1);
        b_fwd = c_fwd[2];
        send(1'b0, 2); tick(2);
        cmp("R7 forward active", 32'(c_fwd[2] - b_fwd), 32'd1);

        // R8: wake sleeping link, three queued packets
        link[7:6] = 2'd1; b_fwd = c_fwd[3];
        send(1'b0, 3); tick(2); send(1'b0, 3); send(1'b0, 3); tick(3);
        cmp("R8 retrain held", 32'(o_rt[3]), 32'd1);
        cmp("R8 nothing forwarded yet", 32'(c_fwd[3] - b_fwd), 32'd0);
        link[7:6] = 2'd0; rdone = 4'b1000; tick(1); clr(); tick(6);
        cmp("R8 all forwarded", 32'(c_fwd[3] - b_fwd), 32'd3);
        cmp("R8 retrain dropped", 32'(o_rt[3]), 32'd0);

        // R10: local packet in idle
        b_fwd = c_fwd[1];
        send(1'b1, 1); tick(3);
        cmp("R10 local idle", 32'(c_fwd[1] - b_fwd), 32'd0);
        tick(30);

        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #400000;
        if (!fin) begin
            fin = 1;
            errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule